// File: doc/BRIEF.md
# Instruction Displacement and Immediate Extractor

This block sits behind an instruction decoder, after the opcode and addressing bytes have been consumed. For each instruction the decoder pulses a start strobe together with side-band information: how many displacement bytes follow, how many immediate bytes follow, whether the operand size is 16 or 32 bits, and whether the immediate is a signed quantity. The remaining instruction bytes are then offered one per cycle with a valid flag.

The block routes the first bytes into a displacement field and the bytes after them into an immediate field. It packs each field with the earliest byte in the least significant position. It widens both fields to the operand size and presents them with a single-cycle done pulse. The displacement is always treated as signed. The immediate is sign-extended or zero-extended under control of the signed flag. A fresh start abandons any collection already under way.

Top module: `idx_extract`

## Requirements
- R1: The length inputs `disp_len_i` and `imm_len_i` use the code 0 = absent, 1 = one byte, 2 = two bytes, 3 = four bytes. The code is latched when `start_i` is high.
- R2: After a start, the first accepted bytes (as many as the displacement length) form the displacement. The next accepted bytes (as many as the immediate length) form the immediate.
- R3: Within each field the first accepted byte occupies bits 7:0, the second bits 15:8, and so on.
- R4: The displacement is sign-extended from its top received bit to the operand size.
- R5: When `imm_signed_i` was 1 at start, the immediate is sign-extended. Otherwise it is zero-extended. For example, byte F6h at 32-bit size gives FFFFFFF6h signed and 000000F6h unsigned.
- R6: `op32_i` = 1 selects a 32-bit operand size and 0 selects 16 bits. At 16 bits, output bits 31:16 are zero and any field bits above bit 15 are dropped.
- R7: A field whose width equals the operand size (4 bytes at 32, 2 bytes at 16) is output unchanged.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final expected byte is accepted. `disp_o` and `imm_o` take their new values in that same cycle and hold them until the next done.
- R9: When both lengths are zero, `done_o` is high in the cycle after the start and both outputs are zero.
- R10: A start during collection restarts it. Partially gathered bytes and the byte count are discarded.
- R11: `byte_vld_i` is ignored while no collection is in progress and in the cycle in which `start_i` is high.
- R12: While `rst_n` is low, and in the first cycle after reset is released, `done_o` is 0 and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a new instruction and latches the side-band inputs |
| disp_len_i | input | 2 | Displacement length code |
| imm_len_i | input | 2 | Immediate length code |
| op32_i | input | 1 | Operand size select: 1 = 32 bits, 0 = 16 bits |
| imm_signed_i | input | 1 | Selects sign extension of the immediate |
| byte_vld_i | input | 1 | `byte_i` holds an instruction byte this cycle |
| byte_i | input | 8 | Instruction byte |
| done_o | output | 1 | One-cycle pulse: both fields are complete |
| disp_o | output | 32 | Extended displacement |
| imm_o | output | 32 | Extended immediate |

## Verification
The assertions assume that the upstream decoder offers bytes only after a start, and that it keeps the side-band inputs meaningful only in the start cycle. Under those assumptions the byte count never reaches the latched total while collection is busy. The stimulus raises `start_i` for a single cycle and leaves `byte_vld_i` low between instructions, except in the one directed test that drives stray bytes while idle and in the start cycle. That test checks that such bytes neither write a field nor shorten the count.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int FIELD_W = BYTE_W * LANES;
  localparam int HALF_W  = FIELD_W / 2;
  localparam int CNT_W   = $clog2(2 * LANES + 1);

  typedef enum logic [1:0] {
    LEN_NONE = 2'd0,
    LEN_ONE  = 2'd1,
    LEN_TWO  = 2'd2,
    LEN_FOUR = 2'd3
  } len_code_t;

  // Byte count encoded by a length code.
  function automatic logic [CNT_W-1:0] len_bytes(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    case (len_code_t'(code))
      LEN_NONE: n = '0;
      LEN_ONE:  n = CNT_W'(1);
      LEN_TWO:  n = CNT_W'(2);
      default:  n = CNT_W'(LANES);
    endcase
    return n;
  endfunction

  // Widen an nbytes-long little-endian field, then trim to operand size.
  function automatic logic [FIELD_W-1:0] extend_field(
    input logic [FIELD_W-1:0] raw,
    input logic [CNT_W-1:0]   nbytes,
    input logic               sgn,
    input logic               wide
  );
    logic [FIELD_W-1:0] v;
    int top;
    top = int'(nbytes) * BYTE_W - 1;
    v = '0;
    if (nbytes != '0) begin
      for (int i = 0; i < FIELD_W; i++) begin
        if (i <= top) v[i] = raw[i];
        else          v[i] = sgn & raw[top];
      end
    end
    if (!wide) v[FIELD_W-1:HALF_W] = '0;
    return v;
  endfunction
endpackage

// File: rtl/idx_seq.sv
module idx_seq
  import idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       disp_code_i,
  input  logic [1:0]       imm_code_i,
  input  logic             op32_i,
  input  logic             sgn_i,
  input  logic             byte_vld_i,
  output logic             busy_o,
  output logic             wr_disp_o,
  output logic             wr_imm_o,
  output logic [CNT_W-1:0] lane_o,
  output logic             last_o,
  output logic             zero_start_o,
  output logic [CNT_W-1:0] dlen_o,
  output logic [CNT_W-1:0] ilen_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] total_o,
  output logic             op32_o,
  output logic             sgn_o
);
  logic [CNT_W-1:0] dlen_q, ilen_q, cnt_q;
  logic [CNT_W-1:0] total_w, start_total_w, imm_idx_w;
  logic             busy_q, op32_q, sgn_q;
  logic             accept_w, in_disp_w;

  assign total_w       = dlen_q + ilen_q;
  assign start_total_w = len_bytes(disp_code_i) + len_bytes(imm_code_i);
  assign accept_w      = busy_q & byte_vld_i & ~start_i;
  assign in_disp_w     = cnt_q < dlen_q;
  assign imm_idx_w     = cnt_q - dlen_q;

  assign wr_disp_o    = accept_w & in_disp_w;
  assign wr_imm_o     = accept_w & ~in_disp_w;
  assign lane_o       = in_disp_w ? cnt_q : imm_idx_w;
  assign last_o       = accept_w & ((cnt_q + CNT_W'(1)) == total_w);
  assign zero_start_o = start_i & (start_total_w == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlen_q <= '0;
      ilen_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op32_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (start_i) begin
      dlen_q <= len_bytes(disp_code_i);
      ilen_q <= len_bytes(imm_code_i);
      cnt_q  <= '0;
      busy_q <= (start_total_w != '0);
      op32_q <= op32_i;
      sgn_q  <= sgn_i;
    end else if (accept_w) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign dlen_o  = dlen_q;
  assign ilen_o  = ilen_q;
  assign cnt_o   = cnt_q;
  assign total_o = total_w;
  assign op32_o  = op32_q;
  assign sgn_o   = sgn_q;
endmodule

// File: rtl/idx_gather.sv
module idx_gather
  import idx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               wr_disp_i,
  input  logic               wr_imm_i,
  input  logic [CNT_W-1:0]   lane_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [FIELD_W-1:0] disp_nxt_o,
  output logic [FIELD_W-1:0] imm_nxt_o
);
  localparam int NFIELD = 2;

  logic [NFIELD-1:0]              wr_w;
  logic [NFIELD-1:0][FIELD_W-1:0] nxt_w;

  assign wr_w = {wr_imm_i, wr_disp_i};

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      logic              hit_w;
      assign hit_w = wr_w[f] && (lane_i == CNT_W'(j));
      always_ff @(posedge clk) begin
        if (!rst_n || clear_i) lane_q <= '0;
        else if (hit_w)        lane_q <= byte_i;
      end
      assign nxt_w[f][j*BYTE_W +: BYTE_W] = hit_w ? byte_i : lane_q;
    end
  end

  assign disp_nxt_o = nxt_w[0];
  assign imm_nxt_o  = nxt_w[1];
endmodule

// File: rtl/idx_extend.sv
module idx_extend
  import idx_pkg::*;
(
  input  logic [FIELD_W-1:0] raw_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  input  logic               sgn_i,
  input  logic               wide_i,
  output logic [FIELD_W-1:0] val_o
);
  assign val_o = extend_field(raw_i, nbytes_i, sgn_i, wide_i);
endmodule

// File: rtl/idx_extract.sv
module idx_extract
  import idx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         disp_len_i,
  input  logic [1:0]         imm_len_i,
  input  logic               op32_i,
  input  logic               imm_signed_i,
  input  logic               byte_vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               done_o,
  output logic [FIELD_W-1:0] disp_o,
  output logic [FIELD_W-1:0] imm_o
);
  logic             busy_w, wr_disp_w, wr_imm_w, last_w, zero_start_w;
  logic             op32_w, sgn_w;
  logic [CNT_W-1:0] lane_w, dlen_w, ilen_w, cnt_w, total_w;
  logic [FIELD_W-1:0] disp_raw_w, imm_raw_w, disp_ext_w, imm_ext_w;
  logic               done_q;
  logic [FIELD_W-1:0] disp_q, imm_q;

  idx_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .disp_code_i  (disp_len_i),
    .imm_code_i   (imm_len_i),
    .op32_i       (op32_i),
    .sgn_i        (imm_signed_i),
    .byte_vld_i   (byte_vld_i),
    .busy_o       (busy_w),
    .wr_disp_o    (wr_disp_w),
    .wr_imm_o     (wr_imm_w),
    .lane_o       (lane_w),
    .last_o       (last_w),
    .zero_start_o (zero_start_w),
    .dlen_o       (dlen_w),
    .ilen_o       (ilen_w),
    .cnt_o        (cnt_w),
    .total_o      (total_w),
    .op32_o       (op32_w),
    .sgn_o        (sgn_w)
  );

  idx_gather i_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .wr_disp_i  (wr_disp_w),
    .wr_imm_i   (wr_imm_w),
    .lane_i     (lane_w),
    .byte_i     (byte_i),
    .disp_nxt_o (disp_raw_w),
    .imm_nxt_o  (imm_raw_w)
  );

  // Displacements are always signed; the immediate follows the latched flag.
  idx_extend i_ext_disp (
    .raw_i    (disp_raw_w),
    .nbytes_i (dlen_w),
    .sgn_i    (1'b1),
    .wide_i   (op32_w),
    .val_o    (disp_ext_w)
  );

  idx_extend i_ext_imm (
    .raw_i    (imm_raw_w),
    .nbytes_i (ilen_w),
    .sgn_i    (sgn_w),
    .wide_i   (op32_w),
    .val_o    (imm_ext_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      disp_q <= '0;
      imm_q  <= '0;
    end else begin
      done_q <= last_w | zero_start_w;
      if (zero_start_w) begin
        disp_q <= '0;
        imm_q  <= '0;
      end else if (last_w) begin
        disp_q <= disp_ext_w;
        imm_q  <= imm_ext_w;
      end
    end
  end

  assign done_o = done_q;
  assign disp_o = disp_q;
  assign imm_o  = imm_q;
endmodule

// File: rtl/idx_checker.sv
module idx_checker
  import idx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               done_o,
  input logic [FIELD_W-1:0] disp_o,
  input logic [FIELD_W-1:0] imm_o,
  input logic               last_w,
  input logic               zero_start_w,
  input logic               busy_w,
  input logic               wr_disp_w,
  input logic               wr_imm_w,
  input logic [CNT_W-1:0]   cnt_w,
  input logic [CNT_W-1:0]   total_w,
  input logic [CNT_W-1:0]   dlen_w,
  input logic               op32_w
);
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(last_w) || $past(zero_start_w))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o || $past(zero_start_w))); // R8

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(disp_o) && $stable(imm_o))); // R8

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start_w |=> (done_o && disp_o == '0 && imm_o == '0)); // R9

  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op32_w) |-> (disp_o[FIELD_W-1:HALF_W] == '0 &&
                             imm_o[FIELD_W-1:HALF_W] == '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (!wr_disp_w && !wr_imm_w)); // R11

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (cnt_w < total_w)); // R2

  AST_IMM_AFTER_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_imm_w |-> (cnt_w >= dlen_w)); // R2
endmodule

bind idx_extract idx_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_o       (done_o),
  .disp_o       (disp_o),
  .imm_o        (imm_o),
  .last_w       (last_w),
  .zero_start_w (zero_start_w),
  .busy_w       (busy_w),
  .wr_disp_w    (wr_disp_w),
  .wr_imm_w     (wr_imm_w),
  .cnt_w        (cnt_w),
  .total_w      (total_w),
  .dlen_w       (dlen_w),
  .op32_w       (op32_w)
);

// File: tb/test_idx_extract.sv
`timescale 1ns/1ps
module test_idx_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  disp_len_i = 2'd0;
  logic [1:0]  imm_len_i = 2'd0;
  logic        op32_i = 1'b0;
  logic        imm_signed_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        done_o;
  logic [31:0] disp_o, imm_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  idx_extract i_idx_extract (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .disp_len_i(disp_len_i),
    .imm_len_i(imm_len_i), .op32_i(op32_i), .imm_signed_i(imm_signed_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .done_o(done_o),
    .disp_o(disp_o), .imm_o(imm_o)
  );

  typedef struct packed {
    logic [1:0]  dl;
    logic [1:0]  il;
    logic        op32;
    logic        sgn;
    logic [63:0] bytes;   // first byte in bits 7:0
    logic [31:0] edisp;
    logic [31:0] eimm;
  } vec_t;

  // R1 codes: 0 none, 1 one byte, 2 two bytes, 3 four bytes.
  localparam vec_t VECS [9] = '{
    '{2'd1, 2'd1, 1'b1, 1'b1, 64'h0000_0000_0000_80F6, 32'hFFFF_FFF6, 32'hFFFF_FF80},
    '{2'd0, 2'd1, 1'b1, 1'b0, 64'h0000_0000_0000_00F6, 32'h0000_0000, 32'h0000_00F6},
    '{2'd3, 2'd3, 1'b1, 1'b1, 64'h89AB_CDEF_1234_5678, 32'h1234_5678, 32'h89AB_CDEF},
    '{2'd2, 2'd2, 1'b1, 1'b0, 64'h0000_0000_FFFE_8234, 32'hFFFF_8234, 32'h0000_FFFE},
    '{2'd2, 2'd1, 1'b0, 1'b1, 64'h0000_0000_0085_8000, 32'h0000_8000, 32'h0000_FF85},
    '{2'd3, 2'd0, 1'b0, 1'b0, 64'h0000_0000_4433_2211, 32'h0000_2211, 32'h0000_0000},
    '{2'd1, 2'd2, 1'b0, 1'b0, 64'h0000_0000_00AB_CD7F, 32'h0000_007F, 32'h0000_ABCD},
    '{2'd0, 2'd3, 1'b1, 1'b0, 64'h0000_0000_8000_0001, 32'h0000_0000, 32'h8000_0001},
    '{2'd1, 2'd3, 1'b0, 1'b1, 64'h0000_0011_2233_4480, 32'h0000_FF80, 32'h0000_3344}
  };

  function automatic int code_len(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic pulse_start(input logic [1:0] dl, input logic [1:0] il,
                             input logic op32, input logic sgn);
    @(negedge clk);
    start_i = 1'b1; disp_len_i = dl; imm_len_i = il;
    op32_i = op32; imm_signed_i = sgn; byte_vld_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Drive one byte at the current negedge; move to the next negedge.
  task automatic put_byte(input logic [7:0] b);
    byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit gap);
    int n;
    n = code_len(v.dl) + code_len(v.il);
    pulse_start(v.dl, v.il, v.op32, v.sgn);
    for (int k = 0; k < n; k++) begin
      if (gap && k == 1) begin
        @(negedge clk);
        chk("R8 no done during gap", {31'b0, done_o}, 32'd0);
      end
      put_byte(v.bytes[k*8 +: 8]);
      if (k < n - 1) chk("R8 no early done", {31'b0, done_o}, 32'd0);
    end
    chk("R8 done after final byte", {31'b0, done_o}, 32'd1);
    chk("R1 R2 R3 R4 R6 R7 displacement", disp_o, v.edisp);
    chk("R1 R2 R3 R5 R6 R7 immediate", imm_o, v.eimm);
    @(negedge clk);
    chk("R8 done one cycle", {31'b0, done_o}, 32'd0);
    chk("R8 displacement held", disp_o, v.edisp);
    chk("R8 immediate held", imm_o, v.eimm);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 done in reset", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 done after reset", {31'b0, done_o}, 32'd0);
    chk("R12 displacement after reset", disp_o, 32'd0);
    chk("R12 immediate after reset", imm_o, 32'd0);

    // Table walk: R1..R8
    foreach (VECS[i]) run_vec(VECS[i], i[0]);

    // R9: both lengths zero
    pulse_start(2'd0, 2'd0, 1'b1, 1'b1);
    chk("R9 done after empty start", {31'b0, done_o}, 32'd1);
    chk("R9 displacement zero", disp_o, 32'd0);
    chk("R9 immediate zero", imm_o, 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", {31'b0, done_o}, 32'd0);

    // R10: restart in the middle of a four-byte displacement
    pulse_start(2'd3, 2'd0, 1'b1, 1'b0);
    put_byte(8'hAA);
    put_byte(8'hBB);
    pulse_start(2'd3, 2'd0, 1'b1, 1'b0);
    put_byte(8'h01);
    put_byte(8'h02);
    chk("R10 no done from stale count", {31'b0, done_o}, 32'd0);
    put_byte(8'h03);
    put_byte(8'h04);
    chk("R10 done after restart", {31'b0, done_o}, 32'd1);
    chk("R10 partial bytes discarded", disp_o, 32'h0403_0201);

    // R11: stray bytes while idle
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      byte_vld_i = 1'b1; byte_i = 8'h55;
      @(negedge clk);
      chk("R11 no done from idle byte", {31'b0, done_o}, 32'd0);
    end
    chk("R11 output unchanged by idle bytes", disp_o, 32'h0403_0201);

    // R11: byte offered in the start cycle is ignored
    start_i = 1'b1; disp_len_i = 2'd1; imm_len_i = 2'd0;
    op32_i = 1'b1; imm_signed_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'hEE;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 start-cycle byte not counted", {31'b0, done_o}, 32'd0);
    put_byte(8'h12);
    chk("R11 done after real byte", {31'b0, done_o}, 32'd1);
    chk("R11 R4 start-cycle byte not stored", disp_o, 32'h0000_0012);
    chk("R11 R9 immediate absent", imm_o, 32'd0);

    summary();
    $finish;
  end
endmodule